// File: doc/BRIEF.md
# Paged Program Counter with Two-Level Return Stack

This block keeps the instruction address for a 2K-word program store. It counts upward one word per increment strobe, and it loads new addresses for direct jumps, subroutine calls and computed writes of the low address byte. The upper two address bits of every loaded target come from a pair of page-select bits. Those bits are held in a register outside the block, and the block only receives their value.

Return addresses are kept in a small hardware stack that is as wide as the counter. The stack never signals overflow or underflow. A call pushes the oldest entry off the bottom. A return copies the bottom entry upward, so the bottom entry is left in place. Both stack levels are brought out on the ports so that the surrounding core and the bench can observe them.

Top module: `paged_pc`

## Requirements
- R1: Asynchronous reset (rst_ni low) and synchronous reset (sync_rst_i) both set pc_o to 7FFh. Synchronous reset leaves both stack levels unchanged.
- R2: An increment adds one to the full 11-bit address, so 1FFh becomes 200h. The page input has no effect on an increment.
- R3: Incrementing 7FFh gives 000h (the address wraps modulo 2048).
- R4: A jump loads pc_o with {page_i[1:0], jmp_tgt_i[8:0]}, with the page bits in pc_o[10:9].
- R5: A call or a low-byte write loads pc_o with {page_i[1:0], 1'b0, low_tgt_i[7:0]}, so pc_o[8] is always 0.
- R6: A call moves level 1 (stk_o[10:0]) into level 2 (stk_o[21:11]) and writes the old pc_o + 1 into level 1.
- R7: After three or more nested calls, only the two most recent return addresses are held.
- R8: A return loads pc_o from level 1 and copies level 2 into level 1, and level 2 keeps its value.
- R9: Repeated returns keep yielding the level-2 address, restored in full (all 11 bits) whatever page_i holds.
- R10: When several requests arrive in one cycle, only the highest one acts. The order, highest first, is: synchronous reset, return, call, low-byte write, jump, increment.
- R11: With no request, pc_o and both stack levels hold their values.
- R12: A low-byte write, a jump and an increment leave both stack levels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_rst_i | input | 1 | Synchronous reset request |
| inc_i | input | 1 | Sequential increment strobe |
| jmp_i | input | 1 | Direct jump request |
| jmp_tgt_i | input | 9 | Jump target field |
| call_i | input | 1 | Subroutine call request |
| low_wr_i | input | 1 | Computed write of the low address byte |
| low_tgt_i | input | 8 | Target byte for a call or a low-byte write |
| page_i | input | 2 | Page-select bits from the external register |
| ret_i | input | 1 | Return request |
| pc_o | output | 11 | Current program counter |
| stk_o | output | 22 | Stack levels; level 1 in [10:0], level 2 in [21:11] |

## Verification
The assertions assume that every request input, target field and page input is at a defined 0 or 1 at each rising edge. They also assume that the stack holds defined values only after two calls, because no reset clears it. The bench changes inputs only on falling edges, so all inputs are stable at each rising edge. Its reference model marks each stack level as known only after a call has written it, and it compares stack contents only once they are known. Requests that arrive together are made by a pseudo-random generator and are never left undriven.

// File: rtl/paged_pc_pkg.sv
package paged_pc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INC,
    OP_JMP,
    OP_LOW,
    OP_CALL,
    OP_RET,
    OP_RST
  } pc_op_e;
endpackage

// File: rtl/paged_pc_arb.sv
module paged_pc_arb
  import paged_pc_pkg::*;
(
  input  logic   rst_req_i,
  input  logic   ret_req_i,
  input  logic   call_req_i,
  input  logic   low_req_i,
  input  logic   jmp_req_i,
  input  logic   inc_req_i,
  output pc_op_e op_o
);
  always_comb begin
    if (rst_req_i)       op_o = OP_RST;
    else if (ret_req_i)  op_o = OP_RET;
    else if (call_req_i) op_o = OP_CALL;
    else if (low_req_i)  op_o = OP_LOW;
    else if (jmp_req_i)  op_o = OP_JMP;
    else if (inc_req_i)  op_o = OP_INC;
    else                 op_o = OP_HOLD;
  end

  always_comb begin
    if (rst_req_i) assert_rst_wins_R10: assert (op_o == OP_RST);
  end
endmodule

// File: rtl/paged_pc_target.sv
module paged_pc_target
  import paged_pc_pkg::*;
#(
  parameter int PC_W  = 11,
  parameter int JMP_W = 9,
  parameter int LOW_W = 8
) (
  input  pc_op_e                op_i,
  input  logic [PC_W-1:0]       pc_i,
  input  logic [PC_W-JMP_W-1:0] page_i,
  input  logic [JMP_W-1:0]      jmp_tgt_i,
  input  logic [LOW_W-1:0]      low_tgt_i,
  input  logic [PC_W-1:0]       top_i,
  output logic [PC_W-1:0]       pc_inc_o,
  output logic [PC_W-1:0]       pc_d_o
);
  localparam int GAP_W = JMP_W - LOW_W;

  logic [PC_W-1:0] jmp_addr, low_addr;

  assign pc_inc_o = pc_i + 1'b1;
  assign jmp_addr = {page_i, jmp_tgt_i};
  // bits between the byte target and the page field are forced low
  assign low_addr = {page_i, {GAP_W{1'b0}}, low_tgt_i};

  always_comb begin
    unique case (op_i)
      OP_RST:  pc_d_o = '1;
      OP_RET:  pc_d_o = top_i;
      OP_CALL: pc_d_o = low_addr;
      OP_LOW:  pc_d_o = low_addr;
      OP_JMP:  pc_d_o = jmp_addr;
      OP_INC:  pc_d_o = pc_inc_o;
      default: pc_d_o = pc_i;
    endcase
  end
endmodule

// File: rtl/paged_pc_stack.sv
module paged_pc_stack #(
  parameter int PC_W  = 11,
  parameter int DEPTH = 2
) (
  input  logic                  clk_i,
  input  logic                  push_i,
  input  logic                  pop_i,
  input  logic [PC_W-1:0]       push_val_i,
  output logic [DEPTH*PC_W-1:0] lvl_o
);
  logic [PC_W-1:0] lvl_q [DEPTH];

  // no reset on purpose: contents survive every reset
  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [PC_W-1:0] from_up, from_down;
    if (i == 0) begin : g_first
      assign from_up = push_val_i;
    end else begin : g_mid
      assign from_up = lvl_q[i-1];
    end
    if (i == DEPTH-1) begin : g_last
      assign from_down = lvl_q[i];
    end else begin : g_inner
      assign from_down = lvl_q[i+1];
    end
    always_ff @(posedge clk_i) begin
      if (push_i)     lvl_q[i] <= from_up;
      else if (pop_i) lvl_q[i] <= from_down;
    end
    assign lvl_o[i*PC_W +: PC_W] = lvl_q[i];
  end

  always_comb begin
    assert_push_pop_excl_R10: assert (!(push_i && pop_i));
  end
endmodule

// File: rtl/paged_pc.sv
module paged_pc
  import paged_pc_pkg::*;
#(
  parameter int PC_W      = 11,
  parameter int JMP_W     = 9,
  parameter int LOW_W     = 8,
  parameter int STK_DEPTH = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sync_rst_i,
  input  logic                      inc_i,
  input  logic                      jmp_i,
  input  logic [JMP_W-1:0]          jmp_tgt_i,
  input  logic                      call_i,
  input  logic                      low_wr_i,
  input  logic [LOW_W-1:0]          low_tgt_i,
  input  logic [PC_W-JMP_W-1:0]     page_i,
  input  logic                      ret_i,
  output logic [PC_W-1:0]           pc_o,
  output logic [STK_DEPTH*PC_W-1:0] stk_o
);
  pc_op_e          op;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc;

  paged_pc_arb u_arb (
    .rst_req_i (sync_rst_i),
    .ret_req_i (ret_i),
    .call_req_i(call_i),
    .low_req_i (low_wr_i),
    .jmp_req_i (jmp_i),
    .inc_req_i (inc_i),
    .op_o      (op)
  );

  paged_pc_target #(.PC_W(PC_W), .JMP_W(JMP_W), .LOW_W(LOW_W)) u_tgt (
    .op_i     (op),
    .pc_i     (pc_q),
    .page_i   (page_i),
    .jmp_tgt_i(jmp_tgt_i),
    .low_tgt_i(low_tgt_i),
    .top_i    (stk_o[PC_W-1:0]),
    .pc_inc_o (pc_inc),
    .pc_d_o   (pc_d)
  );

  paged_pc_stack #(.PC_W(PC_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk_i     (clk_i),
    .push_i    (op == OP_CALL),
    .pop_i     (op == OP_RET),
    .push_val_i(pc_inc),
    .lvl_o     (stk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '1;
    else         pc_q <= pc_d;
  end
  assign pc_o = pc_q;

  assert_sync_rst_vec_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rst_i |=> (pc_o == '1));
  assert_sync_rst_stk_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rst_i |=> $stable(stk_o));
  assert_jmp_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_i && !sync_rst_i && !ret_i && !call_i && !low_wr_i)
      |=> (pc_o == {$past(page_i), $past(jmp_tgt_i)}));
  assert_low_bit_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((call_i || low_wr_i) && !sync_rst_i && !ret_i) |=> (pc_o[LOW_W] == 1'b0));
  assert_push_ret_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !sync_rst_i && !ret_i) |=> (stk_o[PC_W-1:0] == $past(pc_o) + 1'b1));
  assert_ret_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !sync_rst_i) |=> (pc_o == $past(stk_o[PC_W-1:0])));
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_rst_i || ret_i || call_i || low_wr_i || jmp_i || inc_i)
      |=> ($stable(pc_o) && $stable(stk_o)));
  assert_no_push_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_rst_i && !ret_i && !call_i) |=> $stable(stk_o));

  if (STK_DEPTH >= 2) begin : g_deep_chk
    assert_shift_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (call_i && !sync_rst_i && !ret_i)
        |=> (stk_o[2*PC_W-1:PC_W] == $past(stk_o[PC_W-1:0])));
    assert_bottom_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i && !sync_rst_i)
        |=> ($stable(stk_o[STK_DEPTH*PC_W-1:(STK_DEPTH-1)*PC_W])));
  end
endmodule

// File: tb/paged_pc_tb_top.sv
module paged_pc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srst = 1'b0, inc = 1'b0, jmp = 1'b0, call = 1'b0, lowr = 1'b0, ret = 1'b0;
  logic [8:0]  jt = '0;
  logic [7:0]  lt = '0;
  logic [1:0]  pg = '0;
  logic [10:0] pc;
  logic [21:0] stk;

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  logic [10:0] m_pc, m_s0, m_s1;
  logic        k0 = 1'b0, k1 = 1'b0;

  always #2 clk = ~clk;

  paged_pc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_rst_i(srst), .inc_i(inc), .jmp_i(jmp),
    .jmp_tgt_i(jt), .call_i(call), .low_wr_i(lowr), .low_tgt_i(lt), .page_i(pg),
    .ret_i(ret), .pc_o(pc), .stk_o(stk)
  );

  task automatic chk(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, let one rising edge act, check on the next falling edge
  task automatic cyc(input logic s, input logic r, input logic c, input logic l,
                     input logic j, input logic i, input logic [1:0] p,
                     input logic [8:0] jv, input logic [7:0] lv, input string tag);
    logic [10:0] inc_v;
    srst = s; ret = r; call = c; lowr = l; jmp = j; inc = i; pg = p; jt = jv; lt = lv;
    @(posedge clk);
    inc_v = m_pc + 11'd1;
    if (s) m_pc = 11'h7FF;
    else if (r) begin m_pc = m_s0; m_s0 = m_s1; k0 = k1; end
    else if (c) begin m_s1 = m_s0; k1 = k0; m_s0 = inc_v; k0 = 1'b1; m_pc = {p, 1'b0, lv}; end
    else if (l) m_pc = {p, 1'b0, lv};
    else if (j) m_pc = {p, jv};
    else if (i) m_pc = inc_v;
    @(negedge clk);
    srst = 0; ret = 0; call = 0; lowr = 0; jmp = 0; inc = 0;
    chk(pc === m_pc, {tag, " pc"}, pc, m_pc);
    if (k0) chk(stk[10:0] === m_s0, {tag, " level1"}, stk[10:0], m_s0);
    if (k1) chk(stk[21:11] === m_s1, {tag, " level2"}, stk[21:11], m_s1);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    m_pc = 11'h7FF; m_s0 = '0; m_s1 = '0;
    repeat (3) @(negedge clk);
    chk(pc === 11'h7FF, "R1 async reset", pc, 11'h7FF);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: wrap from top address
    cyc(0,0,0,0,0,1, 2'd0, '0, '0, "R3 wrap");
    chk(pc === 11'h000, "R3 wrap to zero", pc, 11'h000);
    // R2: carry across a page edge while page input differs
    cyc(0,0,0,0,1,0, 2'd0, 9'h1F0, '0, "R4 jump");
    for (int n = 0; n < 32; n++) cyc(0,0,0,0,0,1, 2'd3, '0, '0, "R2 increment");
    chk(pc === 11'h210, "R2 carry into page 1", pc, 11'h210);
    // R4: every jump target on every page
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 512; t++)
        cyc(0,0,0,0,1,0, p[1:0], t[8:0], '0, "R4 jump sweep");
    // R6 R7: three nested calls
    cyc(0,0,0,0,1,0, 2'd1, 9'h123, '0, "R4 jump");
    cyc(0,0,1,0,0,0, 2'd2, '0, 8'h40, "R6 call a");
    cyc(0,0,1,0,0,0, 2'd3, '0, 8'h80, "R6 call b");
    chk(stk[21:11] === 11'h324, "R6 level2 after two calls", stk[21:11], 11'h324);
    cyc(0,0,1,0,0,0, 2'd0, '0, 8'hFF, "R7 call c");
    chk(stk[10:0] === 11'h681 && stk[21:11] === 11'h441, "R7 two latest kept",
        stk[10:0], 11'h681);
    // R5 R12: low-byte write sweep with stack held
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 256; t++)
        cyc(0,0,0,1,0,0, p[1:0], '0, t[7:0], "R5 R12 low write sweep");
    // R8 R9: returns with unrelated page bits
    cyc(0,1,0,0,0,0, 2'd2, '0, '0, "R8 return 1");
    chk(pc === 11'h681, "R8 first return", pc, 11'h681);
    chk(stk[10:0] === 11'h441 && stk[21:11] === 11'h441, "R8 level copy", stk[10:0], 11'h441);
    cyc(0,1,0,0,0,0, 2'd0, '0, '0, "R9 return 2");
    cyc(0,1,0,0,0,0, 2'd1, '0, '0, "R9 return 3");
    chk(pc === 11'h441, "R9 repeated return", pc, 11'h441);
    // R11: idle
    for (int n = 0; n < 8; n++) cyc(0,0,0,0,0,0, 2'd3, 9'h1AA, 8'h55, "R11 idle");
    // R1: sync reset keeps stack
    cyc(1,0,0,0,0,0, 2'd0, '0, '0, "R1 sync reset");
    chk(pc === 11'h7FF && stk[10:0] === 11'h441, "R1 sync reset vector", pc, 11'h7FF);
    // R10: random simultaneous requests
    for (int n = 0; n < 6000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0] & lf[1] & lf[2], lf[3] & lf[4], lf[5] & lf[6], lf[7] & lf[8], lf[9],
          lf[10], lf[12:11], {lf[15:13], lf[5:0]}, lf[15:8], "R10 mixed requests");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule